// File: doc/BRIEF.md
# Staggered Shared-Bus Slot Sequencer

This block times a memory bus that several processor ports share by dividing each processor cycle into four equal access slots. A base clock ticks four times per processor cycle and steps a registered one-hot ring through slots 0 to 3. Each port owns one slot. The block gives each port a skewed, asymmetric PHI2: low for one slot, then high for three. The port's bus access therefore lands in the last quarter of its high phase, after two slots of address settling.

Per-port bus enables connect a port to the shared bus only during its own slot. Write strobes fire only inside that window. The owning port's address and write data are driven onto shared bus registers. The read data present at the end of the slot is captured per port and held while the other ports take their turns. Every output comes straight from a flip-flop, so no decoder glitch can reach a clock or a select line. The port count is a parameter from 1 to 4. A packed parameter assigns each port its slot.

Top module: `slot_sequencer`

## Requirements
- R1: Reset (synchronous, active high) sets slot_sel to 4'b0001 (bit k is slot k). After reset each base clock edge moves the active bit from slot k to slot k+1, and from slot 3 back to slot 0.
- R2: Exactly one bit of slot_sel is high in every cycle.
- R3: The phi2 of a port whose access slot is s is low exactly while slot (s+1) mod 4 is active and high in the other three slots. This also holds during reset.
- R4: Port p takes its access slot from bits [2p+1:2p] of SLOT_MAP. The default maps port 0 to slot 3, port 1 to slot 0, port 2 to slot 1 and port 3 to slot 2.
- R5: bus_en[p] is high only while slot_sel shows port p's access slot, and at most one bus_en bit is high at a time.
- R6: After reset all bus enables stay low until the ring first returns to slot 0, on the fourth edge after reset. From then on each port is enabled in every cycle of its own slot.
- R7: bus_wr_stb[p] is high in an enabled slot of port p exactly when port_wr[p] was high at the edge that began the slot. It is never high unless bus_en[p] and phi2[p] are both high.
- R8: bus_addr and bus_wdata carry the owning port's port_addr and port_wdata slices as sampled at the edge that began its slot. Both are zero when no port is enabled.
- R9: port_rdata slice p loads bus_rdata at the edge that ends port p's enabled slot and holds its value at every other edge. Reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, four ticks per processor cycle |
| rst | input | 1 | Synchronous active-high reset |
| port_wr | input | NUM_PORTS | Per-port write request |
| port_addr | input | NUM_PORTS*AW | Per-port address, slice p at [p*AW +: AW] |
| port_wdata | input | NUM_PORTS*DW | Per-port write data, slice p at [p*DW +: DW] |
| bus_rdata | input | DW | Read data returned by the shared bus |
| slot_sel | output | 4 | One-hot active slot |
| phi2 | output | NUM_PORTS | Per-port skewed asymmetric processor clock |
| bus_en | output | NUM_PORTS | Per-port connection to the shared bus |
| bus_wr_stb | output | NUM_PORTS | Per-port write strobe on the shared bus |
| bus_addr | output | AW | Shared bus address from the owning port |
| bus_wdata | output | DW | Shared bus write data from the owning port |
| port_rdata | output | NUM_PORTS*DW | Per-port captured read data |

## Verification
The bound checker checks several properties on every cycle: the one-hot rotation of the ring, the fixed phase link between each phi2 and the slot selects, the confinement of enables to their own slot and their mutual exclusion, the gating of write strobes, and the holding of captured read data outside a port's slot. Some behaviour needs a model of absolute time and of what was driven in earlier cycles, so only the bench's scenarios can show it. That covers the four-edge blackout after reset, the exact sampling edge of addresses, data and write requests, and the value loaded into each read register. The bench sweeps every slot for every port across many cycles and across a reset in the middle of a run.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;
  localparam int SLOTS = 4;
  typedef logic [SLOTS-1:0] slot_vec_t;

  // Slot in which a port with access slot acc holds PHI2 low.
  function automatic logic [1:0] low_slot(input logic [1:0] acc);
    return acc + 2'd1;
  endfunction

  // PHI2 level of a port while the ring shows the given slot vector.
  function automatic logic phi2_level(input logic [1:0] acc, input slot_vec_t ring);
    return !ring[low_slot(acc)];
  endfunction

  // One step of the slot ring.
  function automatic slot_vec_t ring_step(input slot_vec_t r);
    return {r[SLOTS-2:0], r[SLOTS-1]};
  endfunction

  localparam slot_vec_t RING_START = slot_vec_t'(1);
endpackage

// File: rtl/slot_ring.sv
module slot_ring
  import slotseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output slot_vec_t ring_q,
  output slot_vec_t ring_d,
  output logic      armed_q,
  output logic      armed_d
);
  // Next-state values are brought out so each lane registers its outputs
  // from the same edge as the ring itself.
  always_comb begin
    ring_d  = rst ? RING_START : ring_step(ring_q);
    armed_d = rst ? 1'b0 : (armed_q | ring_q[SLOTS-1]);
  end

  always_ff @(posedge clk) begin
    ring_q  <= ring_d;
    armed_q <= armed_d;
  end
endmodule

// File: rtl/port_lane.sv
module port_lane
  import slotseq_pkg::*;
#(
  parameter int         DW  = 8,
  parameter logic [1:0] ACC = 2'd0
) (
  input  logic          clk,
  input  logic          rst,
  input  slot_vec_t     ring_d,
  input  logic          armed_d,
  input  logic          wr_req,
  input  logic [DW-1:0] bus_rdata,
  output logic          grant_d,
  output logic          phi2_q,
  output logic          en_q,
  output logic          stb_q,
  output logic [DW-1:0] rd_q
);
  assign grant_d = armed_d & ring_d[ACC];

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q <= phi2_level(ACC, RING_START);
      en_q   <= 1'b0;
      stb_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      phi2_q <= phi2_level(ACC, ring_d);
      en_q   <= grant_d;
      stb_q  <= grant_d & wr_req;
      if (en_q) rd_q <= bus_rdata;
    end
  end
endmodule

// File: rtl/bus_mux.sv
module bus_mux #(
  parameter int NUM_PORTS = 4,
  parameter int AW        = 8,
  parameter int DW        = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PORTS-1:0]    grant_d,
  input  logic [NUM_PORTS*AW-1:0] port_addr,
  input  logic [NUM_PORTS*DW-1:0] port_wdata,
  output logic [AW-1:0]           bus_addr_q,
  output logic [DW-1:0]           bus_wdata_q
);
  logic [AW-1:0] addr_sel;
  logic [DW-1:0] wdata_sel;

  always_comb begin
    addr_sel  = '0;
    wdata_sel = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      addr_sel  |= port_addr[p*AW +: AW]  & {AW{grant_d[p]}};
      wdata_sel |= port_wdata[p*DW +: DW] & {DW{grant_d[p]}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr_q  <= '0;
      bus_wdata_q <= '0;
    end else begin
      bus_addr_q  <= addr_sel;
      bus_wdata_q <= wdata_sel;
    end
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slotseq_pkg::*;
#(
  parameter int         NUM_PORTS = 4,
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter logic [7:0] SLOT_MAP  = 8'b10_01_00_11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PORTS-1:0]    port_wr,
  input  logic [NUM_PORTS*AW-1:0] port_addr,
  input  logic [NUM_PORTS*DW-1:0] port_wdata,
  input  logic [DW-1:0]           bus_rdata,
  output logic [SLOTS-1:0]        slot_sel,
  output logic [NUM_PORTS-1:0]    phi2,
  output logic [NUM_PORTS-1:0]    bus_en,
  output logic [NUM_PORTS-1:0]    bus_wr_stb,
  output logic [AW-1:0]           bus_addr,
  output logic [DW-1:0]           bus_wdata,
  output logic [NUM_PORTS*DW-1:0] port_rdata
);
  slot_vec_t            ring_q, ring_d;
  logic                 armed_q, armed_d;
  logic [NUM_PORTS-1:0] grant_d;

  slot_ring u_ring (
    .clk    (clk),
    .rst    (rst),
    .ring_q (ring_q),
    .ring_d (ring_d),
    .armed_q(armed_q),
    .armed_d(armed_d)
  );

  assign slot_sel = ring_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    localparam logic [1:0] ACC = SLOT_MAP[2*p +: 2];
    port_lane #(.DW(DW), .ACC(ACC)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .ring_d   (ring_d),
      .armed_d  (armed_d),
      .wr_req   (port_wr[p]),
      .bus_rdata(bus_rdata),
      .grant_d  (grant_d[p]),
      .phi2_q   (phi2[p]),
      .en_q     (bus_en[p]),
      .stb_q    (bus_wr_stb[p]),
      .rd_q     (port_rdata[p*DW +: DW])
    );
  end

  bus_mux #(.NUM_PORTS(NUM_PORTS), .AW(AW), .DW(DW)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .grant_d    (grant_d),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .bus_addr_q (bus_addr),
    .bus_wdata_q(bus_wdata)
  );
endmodule

// File: rtl/slotseq_chk.sv
module slotseq_chk
  import slotseq_pkg::*;
#(
  parameter int         NUM_PORTS = 4,
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter logic [7:0] SLOT_MAP  = 8'b10_01_00_11
) (
  input logic                    clk,
  input logic                    rst,
  input logic [SLOTS-1:0]        slot_sel,
  input logic [NUM_PORTS-1:0]    phi2,
  input logic [NUM_PORTS-1:0]    bus_en,
  input logic [NUM_PORTS-1:0]    bus_wr_stb,
  input logic [AW-1:0]           bus_addr,
  input logic [DW-1:0]           bus_wdata,
  input logic [NUM_PORTS*DW-1:0] port_rdata
);
  assert_ring_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slot_sel == {$past(slot_sel[SLOTS-2:0]), $past(slot_sel[SLOTS-1])});

  assert_one_slot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_sel) == 1);

  assert_en_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_en));

  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_en == '0) |-> (bus_addr == '0 && bus_wdata == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [1:0] ACC = SLOT_MAP[2*p +: 2];
    localparam logic [1:0] LOW = low_slot(ACC);

    assert_phi2_phase_R3: assert property (@(posedge clk) disable iff (rst)
      phi2[p] != slot_sel[LOW]);

    assert_en_own_slot_R5: assert property (@(posedge clk) disable iff (rst)
      bus_en[p] |-> slot_sel[ACC]);

    assert_stb_gated_R7: assert property (@(posedge clk) disable iff (rst)
      bus_wr_stb[p] |-> (bus_en[p] && phi2[p]));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !bus_en[p] |=> $stable(port_rdata[p*DW +: DW]));
  end
endmodule

bind slot_sequencer slotseq_chk #(
  .NUM_PORTS(NUM_PORTS), .AW(AW), .DW(DW), .SLOT_MAP(SLOT_MAP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot_sel  (slot_sel),
  .phi2      (phi2),
  .bus_en    (bus_en),
  .bus_wr_stb(bus_wr_stb),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .port_rdata(port_rdata)
);

// File: tb/slot_sequencer_tb.sv
module slot_sequencer_tb;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    port_wr = '0;
  logic [NP*AW-1:0] port_addr = '0;
  logic [NP*DW-1:0] port_wdata = '0;
  logic [DW-1:0]    bus_rdata = '0;
  logic [3:0]       slot_sel;
  logic [NP-1:0]    phi2, bus_en, bus_wr_stb;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata;
  logic [NP*DW-1:0] port_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [DW-1:0] exp_rd [NP];
  logic [NP-1:0] prev_en;

  always #2 clk = ~clk;

  slot_sequencer u_dut (
    .clk(clk), .rst(rst), .port_wr(port_wr), .port_addr(port_addr),
    .port_wdata(port_wdata), .bus_rdata(bus_rdata), .slot_sel(slot_sel),
    .phi2(phi2), .bus_en(bus_en), .bus_wr_stb(bus_wr_stb),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .port_rdata(port_rdata)
  );

  // R4: default mapping port0->3, port1->0, port2->1, port3->2
  function automatic int acc_of(int p);
    return (p + 3) % 4;
  endfunction
  function automatic logic [AW-1:0] addr_of(int t, int p);
    return AW'(t * 13 + p * 29 + 5);
  endfunction
  function automatic logic [DW-1:0] wdata_of(int t, int p);
    return DW'((t * 7) ^ (p * 51));
  endfunction
  function automatic logic [DW-1:0] rdat_of(int t);
    return DW'(t * 37 + 11);
  endfunction
  function automatic logic wr_of(int t, int p);
    return ((t / 4 + p) % 2) == 1;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(int t);
    for (int p = 0; p < NP; p++) begin
      port_wr[p]               = wr_of(t, p);
      port_addr[p*AW +: AW]    = addr_of(t, p);
      port_wdata[p*DW +: DW]   = wdata_of(t, p);
    end
    bus_rdata = rdat_of(t);
  endtask

  // Compare outputs against the arithmetic model for edge t since reset.
  task automatic check_cycle(int t);
    int slot;
    logic [NP-1:0] e_phi, e_en, e_stb;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_wd;
    slot   = t % 4;
    e_addr = '0;
    e_wd   = '0;
    for (int p = 0; p < NP; p++) begin
      if (prev_en[p]) exp_rd[p] = rdat_of(t);          // R9 capture at slot end
      e_phi[p] = (slot != (acc_of(p) + 1) % 4);         // R3
      e_en[p]  = (t >= 4) && (slot == acc_of(p));       // R5, R6
      e_stb[p] = e_en[p] && wr_of(t, p);                // R7
      if (e_en[p]) begin
        e_addr = addr_of(t, p);                         // R8
        e_wd   = wdata_of(t, p);
      end
    end
    prev_en = e_en;
    check(slot_sel == 4'(1 << slot), "R1 slot_sel", 32'(slot_sel), 32'(1 << slot));
    check($countones(slot_sel) == 1, "R2 one-hot", 32'(slot_sel), 32'(1 << slot));
    check(phi2 == e_phi, "R3 phi2", 32'(phi2), 32'(e_phi));
    check(bus_en == e_en, t < 4 ? "R6 bus_en blackout" : "R4 R5 bus_en", 32'(bus_en), 32'(e_en));
    check(bus_wr_stb == e_stb, "R7 wr strobe", 32'(bus_wr_stb), 32'(e_stb));
    check(bus_addr == e_addr, "R8 bus_addr", 32'(bus_addr), 32'(e_addr));
    check(bus_wdata == e_wd, "R8 bus_wdata", 32'(bus_wdata), 32'(e_wd));
    for (int p = 0; p < NP; p++)
      check(port_rdata[p*DW +: DW] == exp_rd[p], "R9 port_rdata",
            32'(port_rdata[p*DW +: DW]), 32'(exp_rd[p]));
  endtask

  task automatic run_phase(int ncyc);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) exp_rd[p] = '0;
    prev_en = '0;
    check_cycle(0);                                     // reset state, R1 R6
    drive(1);
    rst = 1'b0;
    for (int t = 1; t <= ncyc; t++) begin
      @(negedge clk);
      check_cycle(t);
      drive(t + 1);
    end
  endtask

  initial begin
    drive(0);
    run_phase(48);
    run_phase(23);   // reset in mid-cycle, then a full sweep again
    run_phase(40);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule